// File: doc/BRIEF.md
# Recovering Store Address Matcher

This block sits beside the store path of a processor that supports deferred (non-faulting) loads. Each deferred load that failed leaves an entry in an external table: a valid bit, the effective address it tried to read, the destination register it should have filled, and a bit that selects the integer or the floating register file. When a later store writes to the same address, the value being stored is exactly what the failed load should have returned. The matcher turns that store into a repair. It asks the cache to invalidate and flush the line that holds the address, and it writes the stored data into the recorded destination register.

A store is offered on a valid/ready port with its address, its size code, its source register index and file, and the data words already read from that source. In the cycle the store is accepted, the address is compared against every valid table entry, and the lowest-index hit wins. One cycle later the block pulses the invalidate request and starts a write-back stream of one 32-bit word per cycle. The destination and source register indices both step by one per word, and the final word is marked. The write-back port has no ready: the register file must take one write per cycle. Back-pressure runs only on the store port. `st_ready` is low from the cycle after a matching store is accepted until the cycle after its last write. A store that hits nothing is absorbed at once and `st_ready` stays high.

Top module: `store_repair_fwd`

## Requirements
- R1: Table entries with `tbl_valid` low never take part in a match, even when their address equals the store address. A store that matches only such entries produces no invalidate and no writes.
- R2: When several valid entries hold the store address, only the lowest-index one is used: its destination index and file bit drive every write of the sequence.
- R3: For a matching store accepted at clock edge E, `inv_valid` is high for exactly the one cycle following E. `inv_addr` is the store address with its low LINE_OFS_W bits cleared.
- R4: Size code 0 (1 byte) zeroes bits 31:8 of the written word. Size code 1 (2 bytes) zeroes bits 31:16. All other codes write the word unmasked.
- R5: Size codes 0, 1 and 2 give one write. Code 3 (8 bytes) gives two writes, and codes 4 to 7 give four. Write k carries `st_data[32k+31:32k]` and goes to destination index dest+k with source index `st_src`+k, both wrapping modulo 2^RIDX_W.
- R6: `wr_float` equals the matched entry's file bit, whatever `st_src_float` is. `wr_src_float` repeats `st_src_float`.
- R7: Writes appear on consecutive cycles starting the cycle after acceptance. `wr_last` is high only on the final write. `st_ready` is low while any write is presented and high again in the cycle after the final write.
- R8: A store that matches no valid entry causes no invalidate and no write, and `st_ready` stays high.
- R9: During and right after reset, `st_ready` is high and `wr_valid`, `inv_valid` and `wr_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be accepted |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 3 | Store size code (0:1B, 1:2B, 2:4B, 3:8B, 4-7:16B) |
| st_src | input | RIDX_W | First source register index of the store |
| st_src_float | input | 1 | Store source is the floating file |
| st_data | input | 128 | Store data, word k in bits 32k+31:32k |
| tbl_valid | input | N_ENTRIES | Entry valid bits |
| tbl_addr | input | N_ENTRIES*ADDR_W | Captured load addresses, entry i in slice i |
| tbl_dest | input | N_ENTRIES*RIDX_W | Destination register index per entry |
| tbl_float | input | N_ENTRIES | Destination file per entry (1 = floating) |
| inv_valid | output | 1 | Invalidate-and-flush request pulse |
| inv_addr | output | ADDR_W | Line-aligned address to invalidate |
| wr_valid | output | 1 | Register write presented |
| wr_float | output | 1 | Write targets the floating file |
| wr_dst | output | RIDX_W | Destination register index |
| wr_src | output | RIDX_W | Source register index of this word |
| wr_src_float | output | 1 | Source file of this word |
| wr_data | output | 32 | Word to write |
| wr_last | output | 1 | Final write of the sequence |

## Verification
The bench builds the block with four table entries, a 12-bit address, 6-bit register indices and 16-byte lines. With four entries it can sweep every combination of valid bits against every combination of address-equal entries, 256 stores in all, each checked against a priority pick made in the bench. Non-matching entries differ from the store address in a single bit inside the line offset, so an exact-address compare is exercised rather than a line compare. The store size code rotates through every value across the sweep, and register bases chosen near the top of the 6-bit index space make the index wrap on multi-word writes.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_WORDS = 4;
  localparam int DATA_W    = WORD_W * MAX_WORDS;

  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_HALF = 3'd1,
    SZ_WORD = 3'd2,
    SZ_DBL  = 3'd3,
    SZ_QUAD = 3'd4
  } size_code_e;

  // number of 32-bit write steps for a size code
  function automatic logic [2:0] words_for(input logic [2:0] code);
    logic [2:0] n;
    case (code)
      3'd0, 3'd1, 3'd2: n = 3'd1;
      3'd3:             n = 3'd2;
      default:          n = 3'd4;
    endcase
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] mask_for(input logic [2:0] code);
    logic [WORD_W-1:0] m;
    case (code)
      SZ_BYTE: m = WORD_W'(32'h0000_00FF);
      SZ_HALF: m = WORD_W'(32'h0000_FFFF);
      default: m = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/srm_match.sv
module srm_match #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0]        ent_valid,
  input  logic [N_ENTRIES*ADDR_W-1:0] ent_addr,
  input  logic [ADDR_W-1:0]           probe_addr,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [N_ENTRIES-1:0] eq;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_addr[g*ADDR_W +: ADDR_W] == probe_addr);
  end

  // ascending scan: lowest index wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!hit && eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/srm_lane.sv
module srm_lane
  import srm_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        step,
  input  logic [2:0]        size,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw  = data[step*WORD_W +: WORD_W];
    word = raw & mask_for(size);
  end
endmodule

// File: rtl/srm_seq.sv
module srm_seq
  import srm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RIDX_W     = 6,
  parameter int LINE_OFS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [RIDX_W-1:0] src,
  input  logic              src_float,
  input  logic [RIDX_W-1:0] dst,
  input  logic              dst_float,
  input  logic [DATA_W-1:0] data,
  output logic              idle,
  output logic              inv_valid,
  output logic [ADDR_W-1:0] inv_addr,
  output logic              wr_valid,
  output logic              wr_float,
  output logic [RIDX_W-1:0] wr_dst,
  output logic [RIDX_W-1:0] wr_src,
  output logic              wr_src_float,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_last
);
  typedef enum logic {S_IDLE, S_FWD} state_e;

  state_e            state;
  logic              first_q;
  logic [1:0]        step_q;
  logic [2:0]        nw_q;
  logic [2:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [RIDX_W-1:0] src_q;
  logic [RIDX_W-1:0] dst_q;
  logic              sf_q;
  logic              df_q;
  logic [DATA_W-1:0] data_q;
  logic              at_end;

  assign at_end = ({1'b0, step_q} == (nw_q - 3'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      first_q <= 1'b0;
      step_q  <= '0;
      nw_q    <= 3'd1;
      size_q  <= '0;
      addr_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      sf_q    <= 1'b0;
      df_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take && hit) begin
            state   <= S_FWD;
            first_q <= 1'b1;
            step_q  <= '0;
            nw_q    <= words_for(size);
            size_q  <= size;
            addr_q  <= addr;
            src_q   <= src;
            dst_q   <= dst;
            sf_q    <= src_float;
            df_q    <= dst_float;
            data_q  <= data;
          end
        end
        default: begin
          first_q <= 1'b0;
          if (at_end) state  <= S_IDLE;
          else        step_q <= step_q + 2'd1;
        end
      endcase
    end
  end

  srm_lane u_lane (
    .data (data_q),
    .step (step_q),
    .size (size_q),
    .word (wr_data)
  );

  assign idle         = (state == S_IDLE);
  assign wr_valid     = (state == S_FWD);
  assign inv_valid    = wr_valid && first_q;
  assign inv_addr     = {addr_q[ADDR_W-1:LINE_OFS_W], {LINE_OFS_W{1'b0}}};
  assign wr_float     = df_q;
  assign wr_src_float = sf_q;
  assign wr_dst       = dst_q + RIDX_W'(step_q);
  assign wr_src       = src_q + RIDX_W'(step_q);
  assign wr_last      = wr_valid && at_end;
endmodule

// File: rtl/store_repair_fwd.sv
module store_repair_fwd
  import srm_pkg::*;
#(
  parameter int N_ENTRIES  = 8,
  parameter int ADDR_W     = 32,
  parameter int RIDX_W     = 6,
  parameter int LINE_OFS_W = 5,
  localparam int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        st_valid,
  output logic                        st_ready,
  input  logic [ADDR_W-1:0]           st_addr,
  input  logic [2:0]                  st_size,
  input  logic [RIDX_W-1:0]           st_src,
  input  logic                        st_src_float,
  input  logic [DATA_W-1:0]           st_data,
  input  logic [N_ENTRIES-1:0]        tbl_valid,
  input  logic [N_ENTRIES*ADDR_W-1:0] tbl_addr,
  input  logic [N_ENTRIES*RIDX_W-1:0] tbl_dest,
  input  logic [N_ENTRIES-1:0]        tbl_float,
  output logic                        inv_valid,
  output logic [ADDR_W-1:0]           inv_addr,
  output logic                        wr_valid,
  output logic                        wr_float,
  output logic [RIDX_W-1:0]           wr_dst,
  output logic [RIDX_W-1:0]           wr_src,
  output logic                        wr_src_float,
  output logic [WORD_W-1:0]           wr_data,
  output logic                        wr_last
);
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [RIDX_W-1:0] sel_dst;
  logic             sel_float;
  logic             take;
  logic             idle;

  srm_match #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_match (
    .ent_valid  (tbl_valid),
    .ent_addr   (tbl_addr),
    .probe_addr (st_addr),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  assign sel_dst   = tbl_dest[hit_idx*RIDX_W +: RIDX_W];
  assign sel_float = tbl_float[hit_idx];
  assign st_ready  = idle;
  assign take      = st_valid && st_ready;

  srm_seq #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .LINE_OFS_W(LINE_OFS_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .hit          (hit),
    .addr         (st_addr),
    .size         (st_size),
    .src          (st_src),
    .src_float    (st_src_float),
    .dst          (sel_dst),
    .dst_float    (sel_float),
    .data         (st_data),
    .idle         (idle),
    .inv_valid    (inv_valid),
    .inv_addr     (inv_addr),
    .wr_valid     (wr_valid),
    .wr_float     (wr_float),
    .wr_dst       (wr_dst),
    .wr_src       (wr_src),
    .wr_src_float (wr_src_float),
    .wr_data      (wr_data),
    .wr_last      (wr_last)
  );
endmodule

// File: rtl/store_repair_fwd_chk.sv
module store_repair_fwd_chk
  import srm_pkg::*;
#(
  parameter int N_ENTRIES  = 8,
  parameter int ADDR_W     = 32,
  parameter int RIDX_W     = 6,
  parameter int LINE_OFS_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 st_valid,
  input logic                 st_ready,
  input logic [2:0]           st_size,
  input logic [N_ENTRIES-1:0] tbl_valid,
  input logic                 inv_valid,
  input logic [ADDR_W-1:0]    inv_addr,
  input logic                 wr_valid,
  input logic [RIDX_W-1:0]    wr_dst,
  input logic [RIDX_W-1:0]    wr_src,
  input logic [WORD_W-1:0]    wr_data,
  input logic                 wr_last
);
  p_busy_blocks_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !st_ready);

  p_ready_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_last) |=> (st_ready && !wr_valid));

  p_inv_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !inv_valid);

  p_inv_line_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (inv_addr[LINE_OFS_W-1:0] == '0));

  p_byte_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(st_size) == 3'd0) |-> (wr_data[WORD_W-1:8] == '0));

  p_half_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && $past(st_size) == 3'd1) |-> (wr_data[WORD_W-1:16] == '0));

  p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !inv_valid) |->
      ((RIDX_W'(wr_dst - $past(wr_dst)) == RIDX_W'(1)) &&
       (RIDX_W'(wr_src - $past(wr_src)) == RIDX_W'(1))));

  p_empty_table_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && tbl_valid == '0) |=> !wr_valid);
endmodule

bind store_repair_fwd store_repair_fwd_chk #(
  .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .LINE_OFS_W(LINE_OFS_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_size   (st_size),
  .tbl_valid (tbl_valid),
  .inv_valid (inv_valid),
  .inv_addr  (inv_addr),
  .wr_valid  (wr_valid),
  .wr_dst    (wr_dst),
  .wr_src    (wr_src),
  .wr_data   (wr_data),
  .wr_last   (wr_last)
);

// File: tb/store_repair_fwd_tb.sv
module store_repair_fwd_tb;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int RW = 6;
  localparam int LO = 4;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0;
  logic          st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [2:0]    st_size = '0;
  logic [RW-1:0] st_src = '0;
  logic          st_src_float = 1'b0;
  logic [DW-1:0] st_data = '0;
  logic [N-1:0]  tbl_valid = '0;
  logic [N*AW-1:0] tbl_addr = '0;
  logic [N*RW-1:0] tbl_dest = '0;
  logic [N-1:0]  tbl_float = '0;
  logic          inv_valid;
  logic [AW-1:0] inv_addr;
  logic          wr_valid, wr_float, wr_src_float, wr_last;
  logic [RW-1:0] wr_dst, wr_src;
  logic [31:0]   wr_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  store_repair_fwd #(.N_ENTRIES(N), .ADDR_W(AW), .RIDX_W(RW), .LINE_OFS_W(LO)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(st_ready == 1'b1, "R9 ready", st_ready, 1);
    chk(wr_valid == 1'b0, "R9 wr_valid", wr_valid, 0);
    chk(inv_valid == 1'b0, "R9 inv_valid", inv_valid, 0);
    chk(wr_last == 1'b0, "R9 wr_last", wr_last, 0);
    rst_n = 1'b1;

    for (int combo = 0; combo < 256; combo++) begin
      int vmask, mmask, sel, nw;
      logic [2:0] sz;
      logic [31:0] msk;
      vmask = combo & 15;
      mmask = (combo >> 4) & 15;
      sz = 3'(combo % 5);
      if (combo % 17 == 0) sz = 3'd6;
      if (combo % 23 == 0) sz = 3'd5;
      if (combo % 29 == 0) sz = 3'd7;
      nw  = (sz <= 3'd2) ? 1 : (sz == 3'd3) ? 2 : 4;
      msk = (sz == 3'd0) ? 32'hFF : (sz == 3'd1) ? 32'hFFFF : 32'hFFFF_FFFF;

      @(negedge clk);
      st_addr      = AW'(combo * 37 + 5);
      st_size      = sz;
      st_src       = RW'(combo + 60);
      st_src_float = combo[0] ^ combo[5];
      for (int k = 0; k < 4; k++)
        st_data[32*k +: 32] = 32'h9E37_79B9 * (combo + 1) + k * 32'h0101_0101;
      sel = -1;
      for (int i = 0; i < N; i++) begin
        tbl_valid[i] = vmask[i];
        tbl_addr[i*AW +: AW] = mmask[i] ? st_addr : (st_addr ^ AW'(1 << i));
        tbl_dest[i*RW +: RW] = RW'(i * 7 + combo + 50);
        tbl_float[i] = ((combo >> i) ^ i) & 1;
        if (sel < 0 && vmask[i] && mmask[i]) sel = i;
      end
      st_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0;

      if (sel < 0) begin
        // R1 / R8: no valid match, nothing happens
        chk(!wr_valid && !inv_valid, "R8 R1 no action on miss", {inv_valid, wr_valid}, 0);
        chk(st_ready, "R8 ready stays high", st_ready, 1);
      end else begin
        for (int k = 0; k < nw; k++) begin
          logic [31:0] ew;
          ew = st_data[32*k +: 32] & msk;
          chk(wr_valid, "R7 consecutive write", wr_valid, 1);
          chk(!st_ready, "R7 ready low while busy", st_ready, 0);
          chk(inv_valid == (k == 0), "R3 invalidate pulse", inv_valid, k == 0);
          if (k == 0)
            chk(inv_addr == {st_addr[AW-1:LO], {LO{1'b0}}}, "R3 invalidate address",
                inv_addr, {st_addr[AW-1:LO], {LO{1'b0}}});
          chk(wr_dst == RW'(tbl_dest[sel*RW +: RW] + k), "R2 R5 destination index",
              wr_dst, RW'(tbl_dest[sel*RW +: RW] + k));
          chk(wr_src == RW'(st_src + k), "R5 source index", wr_src, RW'(st_src + k));
          chk(wr_data == ew, "R4 R5 write data", wr_data, ew);
          chk(wr_float == tbl_float[sel], "R6 R2 destination file", wr_float, tbl_float[sel]);
          chk(wr_src_float == st_src_float, "R6 source file", wr_src_float, st_src_float);
          chk(wr_last == (k == nw - 1), "R7 last marker", wr_last, k == nw - 1);
          @(negedge clk);
        end
        chk(!wr_valid && st_ready, "R7 idle after last write", {wr_valid, st_ready}, 1);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule